// File: doc/BRIEF.md
# Two-Dimensional Parity Corrector

This block protects a block of data bits arranged as a matrix of `ROWS` rows by `COLS` columns. It computes one even parity bit for each row, one for each column, and one corner bit that covers the row parity bits. At the receiving end it computes these bits again and compares them with the parity bits that came with the data. When exactly one row check and exactly one column check fail, it inverts the data bit where that row and that column cross.

The block has a one-shot parallel interface. A load strobe captures the data matrix together with its received row, column and corner parity bits. One clock later the block presents the corrected matrix, a two-bit status and freshly generated parity bits for the captured data. A sender uses the generated parity outputs. A receiver uses the corrected data and the status. Both sides can share one instance.

Data bit `r*COLS + c` of a matrix bus holds row `r`, column `c`.

Top module: `tdp_corrector`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `valid_o` is 0 and `status_o` is 2'b00. `data_o` and all parity outputs are 0.
- R2: A high `load_i` at a rising edge makes `valid_o` high for exactly the following cycle, and the results appear in that same cycle. Without a load, `data_o`, `status_o` and the parity outputs hold their values.
- R3: `rowpar_o[r]` is the XOR of the `COLS` bits of row `r` of the loaded data, and `colpar_o[c]` is the XOR of the `ROWS` bits of column `c`. `corner_o` is the XOR of all row parity bits. Even parity is used throughout.
- R4: If every row, column and corner check matches, the data passes unchanged and `status_o` is 2'b00 (clean).
- R5: If exactly one row check and exactly one column check fail, the data bit at that row and column is inverted and `status_o` is 2'b01 (corrected).
- R6: A failure that involves only the parity bits is reported as 2'b01 and the data passes unchanged. This covers three cases: exactly one row check fails with no column failure, exactly one column check fails with no row failure, or only the corner check fails. The corner check compares `corner_i` with the XOR of `rowpar_i`.
- R7: Any other pattern of failing checks is reported as 2'b10 (uncorrectable), and the data passes unchanged. Such patterns include two failing columns with no failing row, or two failing rows. Status 2'b11 never occurs.
- R8: Four flipped data bits at the corners of a rectangle cancel in every check. The block then reports 2'b00 and passes the flipped data unchanged.
- R9: `data_o` differs from the loaded data in at most one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe for the inputs |
| data_i | input | ROWS*COLS | Received data matrix |
| rowpar_i | input | ROWS | Received row parity bits |
| colpar_i | input | COLS | Received column parity bits |
| corner_i | input | 1 | Received corner parity bit |
| valid_o | output | 1 | Results valid, one cycle after the load |
| data_o | output | ROWS*COLS | Corrected data matrix |
| status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| rowpar_o | output | ROWS | Generated row parity of the loaded data |
| colpar_o | output | COLS | Generated column parity of the loaded data |
| corner_o | output | 1 | Generated corner parity |

## Verification
The hardest cases to reach are the error patterns that only the combination of row and column checks can tell apart. Examples are a parity bit corrupted alongside a data bit in another row, two flips in one row that are invisible to the row checks, and a rectangle of four flips that no check can see. The bench builds each received matrix from a clean matrix and computes its correct parity in the bench itself. It then applies explicit flip masks to the data bits, row parity, column parity and corner bit. This lets each of these patterns, and single flips at the matrix corners, be placed precisely. Loads are issued back to back so that result ordering is also exercised.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } tdp_status_e;
endpackage

// File: rtl/tdp_syndrome.sv
module tdp_syndrome #(
  parameter int ROWS = 7,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic [W-1:0]    data,
  input  logic [ROWS-1:0] rowpar_rx,
  input  logic [COLS-1:0] colpar_rx,
  input  logic            corner_rx,
  output logic [ROWS-1:0] row_calc,
  output logic [COLS-1:0] col_calc,
  output logic            corner_calc,
  output logic [ROWS-1:0] row_bad,
  output logic [COLS-1:0] col_bad,
  output logic            corner_bad
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_calc[r] = ^data[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] column;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign column[r] = data[r*COLS + c];
    end
    assign col_calc[c] = ^column;
  end

  assign corner_calc = ^row_calc;
  assign row_bad     = row_calc ^ rowpar_rx;
  assign col_bad     = col_calc ^ colpar_rx;
  assign corner_bad  = corner_rx ^ (^rowpar_rx);
endmodule

// File: rtl/tdp_classify.sv
module tdp_classify
  import tdp_pkg::*;
#(
  parameter int ROWS = 7,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic [ROWS-1:0] row_bad,
  input  logic [COLS-1:0] col_bad,
  input  logic            corner_bad,
  output tdp_status_e     status,
  output logic [W-1:0]    flip_mask
);
  logic row_none, col_none, row_one, col_one, cross_hit;

  assign row_none  = (row_bad == '0);
  assign col_none  = (col_bad == '0);
  assign row_one   = $onehot(row_bad);
  assign col_one   = $onehot(col_bad);
  assign cross_hit = row_one && col_one;

  always_comb begin
    if (row_none && col_none)
      status = corner_bad ? ST_FIXED : ST_CLEAN;
    else if (cross_hit)
      status = ST_FIXED;
    else if ((row_one && col_none) || (row_none && col_one))
      status = ST_FIXED;
    else
      status = ST_FATAL;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_fr
    for (genvar c = 0; c < COLS; c++) begin : g_fc
      assign flip_mask[r*COLS + c] = cross_hit & row_bad[r] & col_bad[c];
    end
  end
endmodule

// File: rtl/tdp_corrector.sv
module tdp_corrector
  import tdp_pkg::*;
#(
  parameter int ROWS = 7,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [W-1:0]    data_i,
  input  logic [ROWS-1:0] rowpar_i,
  input  logic [COLS-1:0] colpar_i,
  input  logic            corner_i,
  output logic            valid_o,
  output logic [W-1:0]    data_o,
  output logic [1:0]      status_o,
  output logic [ROWS-1:0] rowpar_o,
  output logic [COLS-1:0] colpar_o,
  output logic            corner_o
);
  logic [ROWS-1:0] row_calc, row_bad;
  logic [COLS-1:0] col_calc, col_bad;
  logic            corner_calc, corner_bad;
  tdp_status_e     status_nx;
  logic [W-1:0]    flip_mask;

  tdp_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .data(data_i), .rowpar_rx(rowpar_i), .colpar_rx(colpar_i),
    .corner_rx(corner_i), .row_calc(row_calc), .col_calc(col_calc),
    .corner_calc(corner_calc), .row_bad(row_bad), .col_bad(col_bad),
    .corner_bad(corner_bad)
  );

  tdp_classify #(.ROWS(ROWS), .COLS(COLS)) u_cls (
    .row_bad(row_bad), .col_bad(col_bad), .corner_bad(corner_bad),
    .status(status_nx), .flip_mask(flip_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      data_o   <= '0;
      status_o <= ST_CLEAN;
      rowpar_o <= '0;
      colpar_o <= '0;
      corner_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        data_o   <= data_i ^ flip_mask;
        status_o <= status_nx;
        rowpar_o <= row_calc;
        colpar_o <= col_calc;
        corner_o <= corner_calc;
      end
    end
  end
endmodule

module tdp_corrector_chk #(
  parameter int ROWS = 7,
  parameter int COLS = 8,
  localparam int W = ROWS * COLS
) (
  input logic            clk,
  input logic            rst,
  input logic            load_i,
  input logic [W-1:0]    data_i,
  input logic            valid_o,
  input logic [W-1:0]    data_o,
  input logic [1:0]      status_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!valid_o && status_o == 2'b00)); // R1
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst) load_i |=> valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !load_i |=> !valid_o); // R2
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (rst) !load_i |=> ($stable(data_o) && $stable(status_o))); // R2
  AST_FLIP_ONLY_FIXED: assert property (@(posedge clk) disable iff (rst) load_i |=> (data_o == $past(data_i) || status_o == 2'b01)); // R5
  AST_FATAL_PASSTHRU: assert property (@(posedge clk) disable iff (rst) load_i |=> (status_o != 2'b10 || data_o == $past(data_i))); // R7
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst) valid_o |-> status_o != 2'b11); // R7
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst) load_i |=> $countones(data_o ^ $past(data_i)) <= 1); // R9
endmodule

bind tdp_corrector tdp_corrector_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .data_i(data_i),
  .valid_o(valid_o), .data_o(data_o), .status_o(status_o)
);

// File: tb/tdp_corrector_bench.sv
module tdp_corrector_bench;
  localparam int ROWS = 7;
  localparam int COLS = 8;
  localparam int W = ROWS * COLS;

  typedef struct {
    logic [W-1:0]    data;
    logic [1:0]      st;
    logic [ROWS-1:0] rp;
    logic [COLS-1:0] cp;
    logic            kp;
    string           req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [ROWS-1:0] rowpar_i = '0;
  logic [COLS-1:0] colpar_i = '0;
  logic corner_i = 1'b0;
  logic valid_o, corner_o;
  logic [W-1:0] data_o;
  logic [1:0] status_o;
  logic [ROWS-1:0] rowpar_o;
  logic [COLS-1:0] colpar_o;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [W-1:0] last_data;
  logic [1:0] last_st;

  always #5 clk = ~clk;

  tdp_corrector #(.ROWS(ROWS), .COLS(COLS)) u_tdp_corrector (
    .clk(clk), .rst(rst), .load_i(load_i), .data_i(data_i),
    .rowpar_i(rowpar_i), .colpar_i(colpar_i), .corner_i(corner_i),
    .valid_o(valid_o), .data_o(data_o), .status_o(status_o),
    .rowpar_o(rowpar_o), .colpar_o(colpar_o), .corner_o(corner_o)
  );

  function automatic logic [ROWS-1:0] rows_of(input logic [W-1:0] d);
    logic [ROWS-1:0] p = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) p[r] ^= d[r*COLS + c];
    return p;
  endfunction

  function automatic logic [COLS-1:0] cols_of(input logic [W-1:0] d);
    logic [COLS-1:0] p = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) p[c] ^= d[r*COLS + c];
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] orig, input logic [W-1:0] dflip,
                      input logic [ROWS-1:0] rflip, input logic [COLS-1:0] cflip,
                      input logic kflip, input logic [1:0] exp_st,
                      input logic [W-1:0] exp_d, input string req);
    exp_t e;
    logic [W-1:0] rx;
    rx = orig ^ dflip;
    @(negedge clk);
    data_i   = rx;
    rowpar_i = rows_of(orig) ^ rflip;
    colpar_i = cols_of(orig) ^ cflip;
    corner_i = (^rows_of(orig)) ^ kflip;
    load_i   = 1'b1;
    e.data = exp_d; e.st = exp_st; e.req = req;
    e.rp = rows_of(rx); e.cp = cols_of(rx); e.kp = ^rows_of(rx);
    sb.push_back(e);
  endtask

  // monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected valid", W'(1), W'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(data_o == e.data, e.req, "data", data_o, e.data);
        check(status_o == e.st, e.req, "status", W'(status_o), W'(e.st));
        check(rowpar_o == e.rp && colpar_o == e.cp && corner_o == e.kp, "R3",
              "generated parity", W'({rowpar_o, colpar_o, corner_o}),
              W'({e.rp, e.cp, e.kp}));
        last_data = e.data;
        last_st = e.st;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [W-1:0] PA = 56'hA5_3C96_0F71_E2D4;
  localparam logic [W-1:0] PB = 56'h13_57_9B_DF_24_68_AC;

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && status_o == 2'b00 && data_o == '0, "R1",
          "reset state", W'({valid_o, status_o}), W'(0));
    rst = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0 && status_o == 2'b00, "R1", "after reset",
          W'({valid_o, status_o}), W'(0));

    send(PA, '0, '0, '0, 1'b0, 2'b00, PA, "R4");
    send('0, '0, '0, '0, 1'b0, 2'b00, '0, "R4");
    send('1, '0, '0, '0, 1'b0, 2'b00, '1, "R4");
    send(PA, W'(1) << 0,  '0, '0, 1'b0, 2'b01, PA, "R5");
    send(PB, W'(1) << 55, '0, '0, 1'b0, 2'b01, PB, "R5");
    send(PB, W'(1) << 29, '0, '0, 1'b0, 2'b01, PB, "R5");
    send(PA, '0, ROWS'(1) << 2, '0, 1'b0, 2'b01, PA, "R6");
    send(PB, '0, '0, COLS'(1) << 7, 1'b0, 2'b01, PB, "R6");
    send(PA, '0, '0, '0, 1'b1, 2'b01, PA, "R6");
    send(PA, (W'(1) << 8) | (W'(1) << 10), '0, '0, 1'b0, 2'b10,
         PA ^ ((W'(1) << 8) | (W'(1) << 10)), "R7");
    send(PB, (W'(1) << 0) | (W'(1) << 9), '0, '0, 1'b0, 2'b10,
         PB ^ ((W'(1) << 0) | (W'(1) << 9)), "R7");
    send(PA, W'(1) << 0, ROWS'(1) << 3, '0, 1'b0, 2'b10, PA ^ W'(1), "R7");
    send(PB, (W'(1) << 0) | (W'(1) << 3) | (W'(1) << 16) | (W'(1) << 19),
         '0, '0, 1'b0, 2'b00,
         PB ^ ((W'(1) << 0) | (W'(1) << 3) | (W'(1) << 16) | (W'(1) << 19)), "R8");
    @(negedge clk);
    load_i = 1'b0;
    data_i = '1;
    rowpar_i = '0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "pending results", W'(sb.size()), W'(0));
    check(valid_o == 1'b0 && data_o == last_data && status_o == last_st, "R2",
          "hold without load", data_o, last_data);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule